// File: doc/BRIEF.md
# Trimmable One-Hertz Tick Prescaler

This block turns a 32.768 kHz clock-enable strobe into a once-per-second event for a seconds counter. It counts reference strobes, and when a full period has been counted it raises a one-cycle tick. A 3-bit trim code scales the period around its nominal length. Each code step moves the period by a fixed number of reference cycles: larger codes give a shorter period, so time runs fast, and smaller codes give a longer period, so time runs slow. Code zero parks the timebase. The trim value arrives from a serial slave as a load strobe plus a 3-bit value.

Alongside the tick the block drives a square wave at the period rate. The wave is high for the first half of each period and low for the second half. It appears only while the supply-valid flag is true. The tick itself keeps running whatever the supply state, so the continuous counter never loses time.

Top module: `trim_tick_divider`

## Requirements
- R1: `tick_o` is high for exactly one cycle. That cycle is the one right after the clock edge where a reference strobe finishes a period.
- R2: The period length, in reference strobes, is NOMINAL_DIV − (code − 3) × TRIM_STEP, with the code read as unsigned. Reset code 3 gives exactly NOMINAL_DIV.
- R3: Code 7 shortens the period to NOMINAL_DIV − 4 × TRIM_STEP. Code 1 lengthens it to NOMINAL_DIV + 2 × TRIM_STEP.
- R4: While code 0 is active, the count stays at zero, no tick is produced and `sq_o` stays low.
- R5: A code loaded while the timebase runs becomes active on the edge that finishes the current period. The period in progress completes with the old length.
- R6: A nonzero code loaded while code 0 is active becomes active one edge after the load edge. Counting starts from zero at that edge, and that edge does not consume a reference strobe.
- R7: While a nonzero code is active and `supply_ok` is high, `sq_o` is high while the count is below half the period (rounded down) and low for the rest of the period.
- R8: `sq_o` is low whenever `supply_ok` is low. The tick keeps its normal timing.
- R9: After reset the active and pending codes are 3, the count is zero and `tick_o` is low. `sq_o` then equals `supply_ok`.
- R10: Cycles without a reference strobe neither advance the count nor produce a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | 32.768 kHz reference strobe, one cycle wide |
| trim_ld | input | 1 | Loads `trim_val` into the pending trim code |
| trim_val | input | TRIM_W | Trim code to load |
| supply_ok | input | 1 | Main supply valid, qualifies the square wave |
| tick_o | output | 1 | One-cycle period tick to the counter core |
| sq_o | output | 1 | Supply-qualified square wave, high in the first half of the period |

## Verification
Continuous strobes at codes 3, 7 and 1 measure the tick-to-tick distance. This separates a correct trim slope from an inverted or wrongly scaled one, and the count of high cycles checks the half-period boundary. Loads are placed mid-period, while parked at code 0, and as a stop request. These show whether the swap waits for the boundary and whether a restart counts from zero. Runs with the supply flag low, and with strobes withheld, separate the gating of the wave from the tick path and from the hold path. A long random mix of sparse strobes, random codes including zero, and supply toggling is checked cycle by cycle against a bench model.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;

  // Period length in reference strobes for a given trim code.
  function automatic int period_len(input int nom, input int step, input int mid, input int code);
    return nom - (code - mid) * step;
  endfunction

  // Number of strobes in the high half of the square wave.
  function automatic int high_len(input int per);
    return per / 2;
  endfunction

  // Counter width large enough for the slowest trim setting.
  function automatic int count_width(input int nom, input int step, input int mid);
    return $clog2(nom + mid * step + 1);
  endfunction

endpackage

// File: rtl/tick_trim_hold.sv
module tick_trim_hold #(
  parameter int TRIM_W   = 3,
  parameter int TRIM_MID = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [TRIM_W-1:0] val,
  input  logic              wrap,
  output logic [TRIM_W-1:0] pend,
  output logic [TRIM_W-1:0] act,
  output logic              restart
);

  localparam logic [TRIM_W-1:0] RST_CODE = TRIM_W'(TRIM_MID);

  // Parked timebase picks up any nonzero pending code at once.
  assign restart = (act == '0) && (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= RST_CODE;
    end else if (ld) begin
      pend <= val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= RST_CODE;
    end else if (wrap || restart) begin
      act <= pend;
    end
  end

endmodule

// File: rtl/tick_div_counter.sv
module tick_div_counter
  import tick_div_pkg::*;
#(
  parameter int TRIM_W      = 3,
  parameter int TRIM_MID    = 3,
  parameter int NOMINAL_DIV = 32768,
  parameter int TRIM_STEP   = 16,
  parameter int CNT_W       = count_width(NOMINAL_DIV, TRIM_STEP, TRIM_MID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [TRIM_W-1:0] act,
  input  logic              restart,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  per,
  output logic              wrap,
  output logic              tick
);

  logic running;

  assign running = (act != '0);
  assign per     = CNT_W'(period_len(NOMINAL_DIV, TRIM_STEP, TRIM_MID, int'(act)));
  assign wrap    = running && ref_en && (cnt == per - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !running) begin
      cnt <= '0;
    end else if (ref_en) begin
      cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= 1'b0;
    end else begin
      tick <= wrap;
    end
  end

endmodule

// File: rtl/tick_wave_gate.sv
module tick_wave_gate
  import tick_div_pkg::*;
#(
  parameter int TRIM_W = 3,
  parameter int CNT_W  = 16
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  per,
  input  logic [TRIM_W-1:0] act,
  input  logic              supply_ok,
  output logic              sq
);

  logic [CNT_W-1:0] half;
  logic             first_half;

  assign half       = CNT_W'(high_len(int'(per)));
  assign first_half = (act != '0) && (cnt < half);
  assign sq         = supply_ok && first_half;

endmodule

// File: rtl/trim_tick_divider.sv
module trim_tick_divider
  import tick_div_pkg::*;
#(
  parameter int TRIM_W      = 3,
  parameter int TRIM_MID    = 3,
  parameter int NOMINAL_DIV = 32768,
  parameter int TRIM_STEP   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              trim_ld,
  input  logic [TRIM_W-1:0] trim_val,
  input  logic              supply_ok,
  output logic              tick_o,
  output logic              sq_o
);

  localparam int CNT_W = count_width(NOMINAL_DIV, TRIM_STEP, TRIM_MID);

  // Internal events brought out as named wires for the checker.
  logic [TRIM_W-1:0] pend_trim;
  logic [TRIM_W-1:0] act_trim;
  logic              restart_evt;
  logic              wrap_evt;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  per_len;

  tick_trim_hold #(
    .TRIM_W  (TRIM_W),
    .TRIM_MID(TRIM_MID)
  ) trim_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (trim_ld),
    .val    (trim_val),
    .wrap   (wrap_evt),
    .pend   (pend_trim),
    .act    (act_trim),
    .restart(restart_evt)
  );

  tick_div_counter #(
    .TRIM_W     (TRIM_W),
    .TRIM_MID   (TRIM_MID),
    .NOMINAL_DIV(NOMINAL_DIV),
    .TRIM_STEP  (TRIM_STEP),
    .CNT_W      (CNT_W)
  ) div_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_en (ref_en),
    .act    (act_trim),
    .restart(restart_evt),
    .cnt    (cnt_q),
    .per    (per_len),
    .wrap   (wrap_evt),
    .tick   (tick_o)
  );

  tick_wave_gate #(
    .TRIM_W(TRIM_W),
    .CNT_W (CNT_W)
  ) wave_i (
    .cnt      (cnt_q),
    .per      (per_len),
    .act      (act_trim),
    .supply_ok(supply_ok),
    .sq       (sq_o)
  );

endmodule

// File: rtl/tick_div_chk.sv
module tick_div_chk #(
  parameter int TRIM_W = 3,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_en,
  input logic              supply_ok,
  input logic              tick_o,
  input logic              sq_o,
  input logic              wrap_evt,
  input logic              restart_evt,
  input logic [TRIM_W-1:0] act_trim,
  input logic [TRIM_W-1:0] pend_trim,
  input logic [CNT_W-1:0]  cnt_q
);

  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  a_r1_tick_after_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> tick_o);

  a_r4_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (act_trim == '0 && $past(act_trim) == '0) |-> (!tick_o && !sq_o && cnt_q == '0));

  a_r5_swap_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (act_trim == $past(pend_trim)));

  a_r5_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_evt && !restart_evt) |=> $stable(act_trim));

  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (cnt_q == '0 && act_trim != '0));

  a_r8_wave_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !sq_o);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_en && !restart_evt && act_trim != '0) |=> $stable(cnt_q));

endmodule

bind trim_tick_divider tick_div_chk #(
  .TRIM_W(TRIM_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_en     (ref_en),
  .supply_ok  (supply_ok),
  .tick_o     (tick_o),
  .sq_o       (sq_o),
  .wrap_evt   (wrap_evt),
  .restart_evt(restart_evt),
  .act_trim   (act_trim),
  .pend_trim  (pend_trim),
  .cnt_q      (cnt_q)
);

// File: tb/trim_tick_divider_tb_top.sv
module trim_tick_divider_tb_top;

  localparam int NOM  = 64;
  localparam int STEP = 4;
  localparam int MID  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_en = 1'b0;
  logic       trim_ld = 1'b0;
  logic [2:0] trim_val = 3'd0;
  logic       supply_ok = 1'b1;
  logic       tick_o;
  logic       sq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Bench reference state
  int m_pend, m_act, m_cnt;
  bit m_tick;
  bit obs_tick, obs_sq;

  trim_tick_divider #(
    .TRIM_W(3), .TRIM_MID(MID), .NOMINAL_DIV(NOM), .TRIM_STEP(STEP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .trim_ld(trim_ld),
    .trim_val(trim_val), .supply_ok(supply_ok), .tick_o(tick_o), .sq_o(sq_o)
  );

  always #10 clk = ~clk;

  // Period rule restated: each code step above mid removes STEP strobes.
  function automatic int b_period(input int code);
    return NOM + STEP * MID - STEP * code;
  endfunction

  function automatic bit b_wave(input int cnt, input int code, input bit sup);
    if (code == 0 || !sup) return 1'b0;
    return (2 * cnt + 1) < b_period(code);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit r, input bit l, input int v);
    bit wrap;
    int old_pend;
    old_pend = m_pend;
    wrap = (m_act != 0) && r && (m_cnt == b_period(m_act) - 1);
    m_tick = wrap;
    if (m_act == 0) begin
      if (old_pend != 0) begin
        m_act = old_pend;
        m_cnt = 0;
      end
    end else if (r) begin
      if (wrap) begin
        m_cnt = 0;
        m_act = old_pend;
      end else begin
        m_cnt++;
      end
    end
    if (l) m_pend = v;
  endtask

  task automatic cyc(input bit r, input bit l, input int v, input bit s);
    ref_en = r; trim_ld = l; trim_val = 3'(v); supply_ok = s;
    @(posedge clk);
    @(negedge clk);
    model_step(r, l, v);
    obs_tick = tick_o;
    obs_sq = sq_o;
    check(obs_tick == m_tick, "R1 tick", int'(obs_tick), int'(m_tick));
    check(obs_sq == b_wave(m_cnt, m_act, s), "R7 wave", int'(obs_sq), int'(b_wave(m_cnt, m_act, s)));
  endtask

  // Run with continuous strobes until a tick; returns cycles taken.
  task automatic run_to_tick(input bit s, output int n);
    n = 0;
    do begin
      cyc(1'b1, 1'b0, 0, s);
      n++;
    end while (!obs_tick && n < 1000);
  endtask

  task automatic measure(input int exp, input string req);
    int n;
    int hi;
    hi = 0;
    n = 0;
    do begin
      cyc(1'b1, 1'b0, 0, 1'b1);
      n++;
      if (obs_sq && !obs_tick) hi++;
    end while (!obs_tick && n < 1000);
    check(n == exp, req, n, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int hi;
    m_pend = MID; m_act = MID; m_cnt = 0; m_tick = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    check(tick_o == 1'b0, "R9 tick after reset", int'(tick_o), 0);
    check(sq_o == 1'b1, "R9 wave after reset", int'(sq_o), 1);

    // R2: nominal period at default code
    run_to_tick(1'b1, n);
    check(n == b_period(3), "R2 first period", n, b_period(3));
    measure(NOM, "R2 nominal period");

    // R7: count high cycles in one period
    hi = 0;
    n = 0;
    do begin
      cyc(1'b1, 1'b0, 0, 1'b1);
      n++;
      if (obs_sq) hi++;
    end while (!obs_tick && n < 1000);
    check(hi == NOM / 2, "R7 high half", hi, NOM / 2);

    // R5: load 7 mid-period; the current period finishes at old length
    repeat (10) cyc(1'b1, 1'b0, 0, 1'b1);
    cyc(1'b1, 1'b1, 7, 1'b1);
    run_to_tick(1'b1, n);
    check(n == NOM - 11, "R5 old length kept", n, NOM - 11);
    // R3: fast code
    measure(NOM - 4 * STEP, "R3 code 7 period");
    cyc(1'b1, 1'b1, 1, 1'b1);
    run_to_tick(1'b1, n);
    measure(NOM + 2 * STEP, "R3 code 1 period");

    // R4: park with code 0
    cyc(1'b1, 1'b1, 0, 1'b1);
    run_to_tick(1'b1, n);
    n = 0;
    repeat (200) begin
      cyc(1'b1, 1'b0, 0, 1'b1);
      if (obs_tick || obs_sq) n++;
    end
    check(n == 0, "R4 parked quiet", n, 0);

    // R6: restart from park with code 5
    cyc(1'b1, 1'b1, 5, 1'b1);
    run_to_tick(1'b1, n);
    check(n == b_period(5) + 1, "R6 restart length", n, b_period(5) + 1);

    // R8: supply low, wave stays low, tick keeps time
    hi = 0;
    n = 0;
    do begin
      cyc(1'b1, 1'b0, 0, 1'b0);
      n++;
      if (obs_sq) hi++;
    end while (!obs_tick && n < 1000);
    check(n == b_period(5), "R8 tick with supply low", n, b_period(5));
    check(hi == 0, "R8 wave gated", hi, 0);

    // R10: no strobes, nothing moves
    repeat (5) cyc(1'b1, 1'b0, 0, 1'b1);
    n = 0;
    repeat (100) begin
      cyc(1'b0, 1'b0, 0, 1'b1);
      if (obs_tick) n++;
    end
    check(n == 0, "R10 idle no tick", n, 0);
    run_to_tick(1'b1, n);
    check(n == b_period(5) - 5, "R10 count held", n, b_period(5) - 5);

    // Random mix against the bench model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 30000; i++) begin
      bit r, l, s;
      int v;
      r = ($urandom % 4) != 0;
      l = ($urandom % 300) == 0;
      v = (($urandom % 5) == 0) ? 0 : int'($urandom % 8);
      s = ($urandom % 50) != 0;
      cyc(r, l, v, s);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule